// File: doc/BRIEF.md
# Shared carry-lookahead adder/subtractor

This block adds, subtracts, increments or decrements 16-bit operands. It uses a single carry-lookahead adder for all four operations. A bank of XOR gates inverts the adder's second input whenever the operation needs the two's complement, and the same select logic supplies the carry-in. When subtracting, the adder therefore forms A plus the inverse of B plus one. Increment and decrement ignore operand B. Increment feeds zero with a carry-in of one. Decrement feeds all ones with a carry-in of zero.

The block is purely combinational, with no clock and no stored state. Its carry network has two levels. Each 4-bit group computes its own internal carries in parallel and reports a group propagate and a group generate. A second-level unit takes those group signals and the carry-in, and produces every group carry-in and the final carry-out in parallel. No carry ripples from group to group. The block also reports the raw carry-out and signed overflow, so that a surrounding datapath can derive flags from them.

Top module: `cla_addsub16`

## Requirements
- R1: With `mode` = 2'b00, `result` equals (`op_a` + `op_b`) mod 2^16.
- R2: With `mode` = 2'b01, `result` equals (`op_a` - `op_b`) mod 2^16.
- R3: With `mode` = 2'b10, `result` equals (`op_a` + 1) mod 2^16, whatever the value of `op_b`.
- R4: With `mode` = 2'b11, `result` equals (`op_a` - 1) mod 2^16, whatever the value of `op_b`.
- R5: `carry_out` is bit 16 of the 17-bit sum of `op_a`, the adder's second input and the carry-in. The second input and carry-in for each mode are:
  - 00: `op_b`, carry-in 0.
  - 01: ~`op_b`, carry-in 1.
  - 10: 0, carry-in 1.
  - 11: 0xFFFF, carry-in 0.

  In mode 01, `carry_out` is therefore 1 exactly when `op_a` >= `op_b` unsigned.
- R6: `overflow` is 1 exactly when the two's complement result does not fit in 16 bits. The cases are:
  - Add: the operands have equal sign bits and `result` bit 15 differs from them.
  - Subtract: the sign bits of `op_a` and `op_b` differ and `result` bit 15 differs from `op_a` bit 15.
  - Increment: only for `op_a` = 0x7FFF.
  - Decrement: only for `op_a` = 0x8000.
- R7: With all inputs zero, `result`, `carry_out` and `overflow` are all zero.
- R8: Every operand pair built from 0x0000, 0x7FFF, 0x8000 and 0xFFFF gives correct `result`, `carry_out` and `overflow` in all four modes. These values exercise full propagate chains across all four groups.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 16 | First operand |
| op_b | input | 16 | Second operand (unused for increment and decrement) |
| mode | input | 2 | 00 add, 01 subtract, 10 increment, 11 decrement |
| result | output | 16 | Sum or difference, modulo 2^16 |
| carry_out | output | 1 | Carry out of bit 15 |
| overflow | output | 1 | Signed overflow: carry into bit 15 XOR carry out of bit 15 |

## Verification
The corner operands 0x0000, 0x7FFF, 0x8000 and 0xFFFF are crossed with each other in every mode. Full-length propagate chains, such as 0xFFFF plus one, show whether the second-level unit carries across all four groups. The sign-boundary values separate a correct overflow from an overflow taken off the wrong carry pair. Random operands with random modes then cover mixed generate and propagate patterns inside groups. In increment and decrement, `op_b` is given random values, so any leak of `op_b` into the adder appears in the result.

// File: rtl/cla_addsub16.sv
module cla_addsub16 #(
  parameter int WIDTH = 16,
  parameter int GW    = 4
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [1:0]       mode,
  output logic [WIDTH-1:0] result,
  output logic             carry_out,
  output logic             overflow
);
  localparam int NG = WIDTH / GW;
  localparam int LW = (GW > NG) ? GW : NG;

  // Parallel carry into position k of a lookahead span: sum-of-products, no ripple.
  function automatic logic la_carry(input logic [LW-1:0] g, input logic [LW-1:0] p,
                                    input logic ci, input int k);
    logic r, term;
    r = 1'b0;
    for (int t = 0; t < LW; t++) begin
      if (t < k) begin
        term = g[t];
        for (int u = 0; u < LW; u++)
          if (u > t && u < k) term = term & p[u];
        r = r | term;
      end
    end
    term = ci;
    for (int u = 0; u < LW; u++)
      if (u < k) term = term & p[u];
    return r | term;
  endfunction

  logic             inv, cin;
  logic [WIDTH-1:0] b_src, b_eff, bp, bg;
  logic [WIDTH:0]   c;
  logic [NG-1:0]    grp_p, grp_g;
  logic [NG:0]      grp_c;
  logic [LW-1:0]    top_p, top_g;

  assign inv   = mode[0];
  assign cin   = mode[1] ^ mode[0];
  assign b_src = mode[1] ? '0 : op_b;
  assign b_eff = b_src ^ {WIDTH{inv}};
  assign bp    = op_a ^ b_eff;
  assign bg    = op_a & b_eff;

  for (genvar j = 0; j < NG; j++) begin : g_grp
    logic [LW-1:0] lp, lg;
    always_comb begin
      lp = '0;
      lg = '0;
      lp[GW-1:0] = bp[j*GW +: GW];
      lg[GW-1:0] = bg[j*GW +: GW];
    end
    assign grp_p[j] = &bp[j*GW +: GW];
    assign grp_g[j] = la_carry(lg, lp, 1'b0, GW);
    for (genvar k = 0; k < GW; k++) begin : g_bit
      assign c[j*GW+k] = la_carry(lg, lp, grp_c[j], k);
    end
  end

  always_comb begin
    top_p = '0;
    top_g = '0;
    top_p[NG-1:0] = grp_p;
    top_g[NG-1:0] = grp_g;
  end

  for (genvar j = 0; j <= NG; j++) begin : g_top
    assign grp_c[j] = la_carry(top_g, top_p, cin, j);
  end

  assign c[WIDTH]   = grp_c[NG];
  assign result     = bp ^ c[WIDTH-1:0];
  assign carry_out  = c[WIDTH];
  assign overflow   = c[WIDTH] ^ c[WIDTH-1];
endmodule

// File: rtl/cla_addsub16_chk.sv
module cla_addsub16_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [1:0]       mode,
  input logic [WIDTH-1:0] result,
  input logic             carry_out,
  input logic             overflow
);
  localparam logic [WIDTH-1:0] ONE  = WIDTH'(1);
  localparam logic [WIDTH-1:0] MAXP = {1'b0, {(WIDTH-1){1'b1}}};
  localparam logic [WIDTH-1:0] MINN = {1'b1, {(WIDTH-1){1'b0}}};

  always_comb begin
    if (!$isunknown({op_a, op_b, mode})) begin
      if (mode == 2'b00)
        AST_ADD_SUM: assert ({carry_out, result} == {1'b0, op_a} + {1'b0, op_b}); // R1
      if (mode == 2'b01)
        AST_SUB_DIFF: assert (result == op_a - op_b && carry_out == (op_a >= op_b)); // R2
      if (mode == 2'b10)
        AST_INC_VAL: assert (result == op_a + ONE && overflow == (op_a == MAXP)); // R3
      if (mode == 2'b11)
        AST_DEC_VAL: assert (result == op_a - ONE && overflow == (op_a == MINN)); // R4
      if (mode == 2'b00)
        AST_ADD_OVF: assert (overflow == ((op_a[WIDTH-1] == op_b[WIDTH-1]) &&
                                          (result[WIDTH-1] != op_a[WIDTH-1]))); // R6
    end
  end
endmodule

bind cla_addsub16 cla_addsub16_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cla_addsub16_bench.sv
module cla_addsub16_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] a, b;
    logic [1:0]  m;
    logic [15:0] res;
    logic        co, ov;
    string       req;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [1:0]  mode = '0;
  logic [15:0] result;
  logic        carry_out, overflow;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  item_t       q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cla_addsub16 u_cla_addsub16 (.op_a, .op_b, .mode, .result, .carry_out, .overflow);

  task automatic drive(input logic [15:0] a, input logic [15:0] b, input logic [1:0] m, input string req);
    item_t it;
    logic [16:0] s;
    logic [15:0] bb;
    logic        ci;
    case (m)
      2'b00: begin bb = b;      ci = 1'b0; end
      2'b01: begin bb = ~b;     ci = 1'b1; end
      2'b10: begin bb = 16'h0;  ci = 1'b1; end
      default: begin bb = 16'hFFFF; ci = 1'b0; end
    endcase
    s = {1'b0, a} + {1'b0, bb} + {16'h0, ci};
    it.a = a; it.b = b; it.m = m; it.res = s[15:0]; it.co = s[16]; it.req = req;
    case (m)
      2'b00: it.ov = (a[15] == b[15]) && (s[15] != a[15]);
      2'b01: it.ov = (a[15] != b[15]) && (s[15] != a[15]);
      2'b10: it.ov = (a == 16'h7FFF);
      default: it.ov = (a == 16'h8000);
    endcase
    @(posedge clk);
    #1;
    op_a = a; op_b = b; mode = m;
    q.push_back(it);
  endtask

  // monitor: one comparison per cycle, half a period after the driver
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (result !== e.res || carry_out !== e.co || overflow !== e.ov) begin
          errors++;
          $display("FAIL %s a=%h b=%h m=%b: got res=%h co=%b ov=%b, exp res=%h co=%b ov=%b",
                   e.req, e.a, e.b, e.m, result, carry_out, overflow, e.res, e.co, e.ov);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] corners [4];
    corners[0] = 16'h0000; corners[1] = 16'h7FFF; corners[2] = 16'h8000; corners[3] = 16'hFFFF;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(16'h0, 16'h0, 2'b00, "R7");
    drive(16'hFFFF, 16'h0001, 2'b00, "R1");
    drive(16'h1234, 16'h1234, 2'b01, "R2");
    drive(16'h0003, 16'h0005, 2'b01, "R5");
    drive(16'hFFFF, 16'hA5A5, 2'b10, "R3");
    drive(16'h0000, 16'h5A5A, 2'b11, "R4");
    drive(16'h7FFF, 16'hFFFF, 2'b10, "R6");
    drive(16'h8000, 16'h1234, 2'b11, "R6");
    drive(16'h8000, 16'h0001, 2'b01, "R6");
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          drive(corners[i], corners[j], 2'(m), "R8");
    for (int n = 0; n < 400; n++) begin
      logic [1:0] m;
      m = 2'($urandom_range(0, 3));
      drive(16'($urandom), 16'($urandom), m,
            m == 2'b00 ? "R1" : m == 2'b01 ? "R2" : m == 2'b10 ? "R3" : "R4");
    end
    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule